// File: doc/BRIEF.md
# Saturating half/bfloat16 to int4 converter

The block turns one 16-bit floating-point operand into a signed 4-bit integer every clock cycle. A select input says whether the operand is IEEE half precision or bfloat16. A mode input picks one of two rounding methods. The first is plain truncation toward zero. The second is stochastic rounding: an unsigned random fraction, supplied from outside the block, is added to the operand's magnitude before truncation.

Results that do not fit the signed 4-bit range are clamped to the extreme on the side of the operand's sign. Infinities are clamped the same way, and NaNs give zero. The operand arrives with a valid strobe. The result leaves through one register stage, with its own valid strobe. The integer width is a parameter and defaults to 4.

Top module: `f2i_top`

## Requirements
- R1: A result and a high `out_valid` appear on the first rising edge after an edge at which `in_valid` was high. After an edge that sampled `in_valid` low, `out_valid` is low.
- R2: While reset is asserted, `out_valid` is 0 and `out_result` is 0000.
- R3: With `in_fmt`=0 the operand is IEEE half: bit 15 sign, bits 14:10 exponent with bias 15, bits 9:0 fraction. With `in_fmt`=1 it is bfloat16: bit 15 sign, bits 14:7 exponent with bias 127, bits 6:0 fraction. An all-zero exponent field denotes a subnormal.
- R4: With `in_mode`=0 the result is the operand truncated toward zero, in two's complement, and `in_bias` has no effect.
- R5: A positive operand whose truncated value exceeds 7, including +infinity, gives 0111. A positive operand never gives a negative result.
- R6: A negative operand whose truncated magnitude is 8 or more, including -infinity, gives 1000.
- R7: Any NaN (all-ones exponent field with a nonzero fraction) gives 0000, in either mode.
- R8: With `in_mode`=1 the magnitude is M = floor((floor(|x|·1024) + B) / 1024), where B is `in_bias` read as an unsigned 10-bit value. The result is +M or -M, saturated as in R5 and R6. A carry out of the fraction raises the integer.
- R9: For bfloat16 operands in stochastic mode, bits 2:0 of `in_bias` are ignored. Only bits 9:3 take part.
- R10: Zero, negative zero and every subnormal operand give 0000 in truncation mode.
- R11: While `in_valid` is low, `out_result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_value | input | 16 | Operand bits |
| in_fmt | input | 1 | 0 = IEEE half, 1 = bfloat16 |
| in_mode | input | 1 | 0 = truncate, 1 = stochastic rounding |
| in_bias | input | 10 | Random fraction for stochastic rounding |
| out_valid | output | 1 | Result strobe |
| out_result | output | OUT_W (4) | Signed result |

## Verification
Every result is due exactly one rising edge after the edge that accepts its operand, because only the output register lies on the path. The bench changes inputs at falling edges and samples `out_valid` and `out_result` 1 ns after the next rising edge. Each check therefore sees the result for the operand it just drove and nothing older. For the hold behaviour, the bench drops `in_valid`, scrambles the operand, waits three edges and then compares against the last result.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  localparam int HALF_MANT = 10;
  localparam int HALF_BIAS = 15;
  localparam int BF_MANT   = 7;
  localparam int BF_BIAS   = 127;
  // common fraction grid: the finer of the two source fractions
  localparam int FRAC_W    = HALF_MANT;
  localparam int EXP_W     = 10;

  typedef enum logic {FMT_HALF = 1'b0, FMT_BF16 = 1'b1} src_fmt_e;
  typedef enum logic {RND_TRUNC = 1'b0, RND_STOCH = 1'b1} rnd_mode_e;

  // value = sig * 2^(exp - FRAC_W)
  typedef struct packed {
    logic                    sign;
    logic                    is_nan;
    logic                    is_inf;
    logic signed [EXP_W-1:0] exp;
    logic [FRAC_W:0]         sig;
  } unpacked_t;

  function automatic unpacked_t unpack_half(input logic [15:0] v);
    unpacked_t u;
    logic [4:0] ef;
    logic [HALF_MANT-1:0] mf;
    ef       = v[14:10];
    mf       = v[9:0];
    u.sign   = v[15];
    u.is_inf = (ef == 5'h1F) && (mf == '0);
    u.is_nan = (ef == 5'h1F) && (mf != '0);
    if (ef == 5'h00) begin
      u.sig = {1'b0, mf};
      u.exp = EXP_W'(1 - HALF_BIAS);
    end else begin
      u.sig = {1'b1, mf};
      u.exp = EXP_W'(int'(ef) - HALF_BIAS);
    end
    return u;
  endfunction

  function automatic unpacked_t unpack_bf16(input logic [15:0] v);
    unpacked_t u;
    logic [7:0] ef;
    logic [BF_MANT-1:0] mf;
    ef       = v[14:7];
    mf       = v[6:0];
    u.sign   = v[15];
    u.is_inf = (ef == 8'hFF) && (mf == '0);
    u.is_nan = (ef == 8'hFF) && (mf != '0);
    if (ef == 8'h00) begin
      u.sig = (FRAC_W+1)'({1'b0, mf}) << (FRAC_W - BF_MANT);
      u.exp = EXP_W'(1 - BF_BIAS);
    end else begin
      u.sig = (FRAC_W+1)'({1'b1, mf}) << (FRAC_W - BF_MANT);
      u.exp = EXP_W'(int'(ef) - BF_BIAS);
    end
    return u;
  endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [15:0] value,
  input  logic        fmt,
  output unpacked_t   u
);
  unpacked_t u_half;
  unpacked_t u_bf16;

  always_comb begin
    u_half = unpack_half(value);
    u_bf16 = unpack_bf16(value);
    u      = (fmt == FMT_BF16) ? u_bf16 : u_half;
  end
endmodule

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  unpacked_t               u,
  input  logic                    fmt,
  input  logic                    mode,
  input  logic [FRAC_W-1:0]       bias,
  output logic                    huge,
  output logic [OUT_W+1:0]        mag
);
  localparam int FX_W  = FRAC_W + 1 + OUT_W;  // holds |x| < 2^OUT_W
  localparam int SUM_W = FX_W + 1;
  localparam int MAG_W = OUT_W + 2;
  localparam logic signed [EXP_W-1:0] SAT_E = EXP_W'(OUT_W);
  localparam logic [FRAC_W-1:0] BF_MASK = ~FRAC_W'((1 << (FRAC_W - BF_MANT)) - 1);

  logic [FX_W-1:0]   fx;
  logic [EXP_W-1:0]  shr;
  logic [FRAC_W-1:0] bias_eff;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    huge = u.is_inf || (u.exp >= SAT_E);
    shr  = EXP_W'(-u.exp);
    if (huge)
      fx = '0;
    else if (u.exp[EXP_W-1])
      fx = FX_W'(u.sig) >> shr;
    else
      fx = FX_W'(u.sig) << $unsigned(u.exp);
  end

  always_comb begin
    if (mode != RND_STOCH)
      bias_eff = '0;
    else if (fmt == FMT_BF16)
      bias_eff = bias & BF_MASK;
    else
      bias_eff = bias;
    sum = SUM_W'(fx) + SUM_W'(bias_eff);
    mag = MAG_W'(sum >> FRAC_W);
  end
endmodule

// File: rtl/f2i_sat.sv
module f2i_sat #(
  parameter int OUT_W = 4
) (
  input  logic             sign,
  input  logic             is_nan,
  input  logic             huge,
  input  logic [OUT_W+1:0] mag,
  output logic [OUT_W-1:0] result,
  output logic             sat_pos,
  output logic             sat_neg
);
  localparam int MAG_W = OUT_W + 2;
  localparam logic [MAG_W-1:0] POS_LIM = MAG_W'((1 << (OUT_W-1)) - 1);
  localparam logic [MAG_W-1:0] NEG_LIM = MAG_W'(1 << (OUT_W-1));
  localparam logic [OUT_W-1:0] POS_CODE = OUT_W'((1 << (OUT_W-1)) - 1);
  localparam logic [OUT_W-1:0] NEG_CODE = OUT_W'(1 << (OUT_W-1));

  always_comb begin
    sat_pos = !is_nan && !sign && (huge || mag > POS_LIM);
    sat_neg = !is_nan &&  sign && (huge || mag > NEG_LIM);
    if (is_nan)
      result = '0;
    else if (sat_pos)
      result = POS_CODE;
    else if (sat_neg)
      result = NEG_CODE;
    else if (sign)
      result = OUT_W'(-mag);
    else
      result = OUT_W'(mag);
  end
endmodule

// File: rtl/f2i_top.sv
module f2i_top
  import f2i_pkg::*;
#(
  parameter int OUT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       in_value,
  input  logic              in_fmt,
  input  logic              in_mode,
  input  logic [FRAC_W-1:0] in_bias,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_result
);
  localparam logic [OUT_W-1:0] POS_CODE = OUT_W'((1 << (OUT_W-1)) - 1);
  localparam logic [OUT_W-1:0] NEG_CODE = OUT_W'(1 << (OUT_W-1));

  unpacked_t          u;
  logic               huge;
  logic [OUT_W+1:0]   mag;
  logic [OUT_W-1:0]   res_c;
  logic               sat_pos;
  logic               sat_neg;
  logic               nan_evt;

  f2i_unpack i_unpack (
    .value (in_value),
    .fmt   (in_fmt),
    .u     (u)
  );

  f2i_align #(.OUT_W(OUT_W)) i_align (
    .u    (u),
    .fmt  (in_fmt),
    .mode (in_mode),
    .bias (in_bias),
    .huge (huge),
    .mag  (mag)
  );

  f2i_sat #(.OUT_W(OUT_W)) i_sat (
    .sign    (u.sign),
    .is_nan  (u.is_nan),
    .huge    (huge),
    .mag     (mag),
    .result  (res_c),
    .sat_pos (sat_pos),
    .sat_neg (sat_neg)
  );

  assign nan_evt = u.is_nan;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_result <= res_c;
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  p_nan_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && nan_evt) |=> (out_result == '0));
  p_sat_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_pos) |=> (out_result == POS_CODE));
  p_sat_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sat_neg) |=> (out_result == NEG_CODE));
  p_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_value[15]) |=> !out_result[OUT_W-1]);
  p_sat_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0({sat_pos, sat_neg, nan_evt}));
endmodule

// File: tb/test_f2i_top.sv
`timescale 1ns/1ps
module test_f2i_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_value = '0;
  logic        in_fmt = 1'b0;
  logic        in_mode = 1'b0;
  logic [9:0]  in_bias = '0;
  logic        out_valid;
  logic [3:0]  out_result;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  f2i_top i_f2i_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_fmt(in_fmt), .in_mode(in_mode), .in_bias(in_bias),
    .out_valid(out_valid), .out_result(out_result)
  );

  function automatic logic [3:0] model(input logic [15:0] v, input bit f,
                                       input bit m, input logic [9:0] b);
    real    a;
    int     ef, mf;
    longint fx, t, bb;
    bit     special;
    special = 0;
    if (!f) begin
      ef = int'(v[14:10]); mf = int'(v[9:0]);
      if (ef == 31) special = 1;
      a = (ef == 0) ? mf * (2.0 ** -24) : (1.0 + mf / 1024.0) * (2.0 ** (ef - 15));
      bb = longint'(b);
    end else begin
      ef = int'(v[14:7]); mf = int'(v[6:0]);
      if (ef == 255) special = 1;
      a = (ef == 0) ? mf * (2.0 ** -133) : (1.0 + mf / 128.0) * (2.0 ** (ef - 127));
      bb = longint'(b & 10'h3F8);
    end
    if (!m) bb = 0;
    if (special && mf != 0) return 4'h0;
    if (special || a >= 16.0) t = 100;
    else begin
      fx = longint'($floor(a * 1024.0));
      t  = (fx + bb) / 1024;
    end
    if (!v[15]) return (t > 7) ? 4'h7 : 4'(t);
    return (t > 8) ? 4'h8 : 4'(-t);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [3:0] got,
                     input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v, input bit f, input bit m,
                       input logic [9:0] b, input string tag);
    logic [3:0] e;
    @(negedge clk);
    in_value = v; in_fmt = f; in_mode = m; in_bias = b; in_valid = 1'b1;
    @(posedge clk); #1;
    e = model(v, f, m, b);
    chk(out_valid === 1'b1, "R1", {3'b0, out_valid}, 4'h1);
    chk(out_result === e, tag, out_result, e);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [3:0] last;
    void'($urandom(32'd4711));
    #1;
    chk(out_valid === 1'b0, "R2", {3'b0, out_valid}, 4'h0);
    chk(out_result === 4'h0, "R2", out_result, 4'h0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    apply(16'h4180, 0, 0, 10'h000, "R4");  // 2.75 -> 2
    apply(16'hC300, 0, 0, 10'h000, "R4");  // -3.5 -> -3
    apply(16'h4180, 0, 0, 10'h3FF, "R4");  // bias ignored
    apply(16'hC0A0, 1, 0, 10'h000, "R3");  // bf16 -5
    apply(16'hC0A0, 0, 0, 10'h000, "R3");  // half -2.3125
    apply(16'h4800, 0, 0, 10'h000, "R5");  // 8.0 -> 7
    apply(16'h7C00, 0, 0, 10'h000, "R5");  // +inf
    apply(16'hC800, 0, 0, 10'h000, "R6");  // -8 exact
    apply(16'hC880, 0, 0, 10'h000, "R6");  // -9
    apply(16'hFC00, 0, 1, 10'h3FF, "R6");  // -inf
    apply(16'h7E00, 0, 0, 10'h000, "R7");
    apply(16'hFE01, 0, 1, 10'h200, "R7");
    apply(16'h7FC1, 1, 0, 10'h000, "R7");
    apply(16'h4180, 0, 1, 10'h100, "R8");  // 2.75+0.25 -> 3
    apply(16'h4180, 0, 1, 10'h0FF, "R8");  // stays 2
    apply(16'hC180, 0, 1, 10'h100, "R8");  // -> -3
    apply(16'h4780, 0, 1, 10'h200, "R8");  // 7.5+0.5 -> saturate 7
    apply(16'h3F7F, 1, 1, 10'h004, "R9");  // low bits dropped -> 0
    apply(16'h3F7F, 1, 1, 10'h008, "R9");  // -> 1
    apply(16'h0001, 0, 0, 10'h000, "R10");
    apply(16'h8000, 0, 0, 10'h000, "R10");
    apply(16'h807F, 1, 0, 10'h000, "R10");

    last = out_result;
    @(negedge clk);
    in_valid = 1'b0; in_value = 16'h4700; in_mode = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid === 1'b0, "R1", {3'b0, out_valid}, 4'h0);
    chk(out_result === last, "R11", out_result, last);

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] v;
      bit f, m;
      v = 16'($urandom());
      f = 1'($urandom());
      m = 1'($urandom());
      if ($urandom_range(0, 3) != 0) begin
        if (!f) v[14:10] = 5'($urandom_range(8, 19));
        else    v[14:7]  = 8'($urandom_range(118, 131));
      end
      apply(v, f, m, 10'($urandom()), m ? "R8" : "R4");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule